// File: doc/BRIEF.md
# Horizontal-Microcode Bus Processor Core

This core runs programs made of 28-bit control words without decoding any opcodes. Each low bit of a word enables one datapath action, and all enabled actions complete together in one clock cycle. There is no program counter. Every word carries two 7-bit addresses: a default successor and an alternate pointer. The control bits, the condition flag and the kind of memory access decide which of the two is fetched next.

The datapath is built around a 28-bit bus register. It also holds a logic operand register, four general-purpose registers, an output register that drives the data-out port, and a single condition flag. Instruction memory and data memory sit outside the core, and both are read combinationally. The instruction address register selects the word to execute. The data address comes from the current word and the current bus. A memory write stores the output register when the clock edge arrives.

Top module: `ucode_core`

## Requirements
- R1: A synchronous reset clears the instruction address, the bus, the logic register, all general registers, the output register and the condition flag to zero.
- R2: When none of bit 0 (immediate load), bit 13 (indirect load) or bit 10 (branch) is set, the next instruction address is the default-successor field, bits 20..14.
- R3: When bit 0 is set, the data address is the default-successor field zero-extended, the bus loads dataIn, and the next address is the alternate field, bits 27..21 (unless bit 10 is set).
- R4: When bit 13 is set, the data address is the current bus value, the bus loads dataIn, and the next address is the alternate field (unless bit 10 is set). Bit 13 outranks bit 0.
- R5: When bit 10 is set, the next address is the default-successor field if the condition flag is 1 and the alternate field if it is 0. This outranks R2 to R4.
- R6: Bits 2..1 select a general register. Bit 4 writes the bus into it, and bit 3 puts its value on the bus.
- R7: Bit 5 copies the bus into the logic register. Bit 7 replaces the bus with bus XOR logic register.
- R8: Bit 6 replaces the bus with (bus AND logic register) rotated left by one place, with bit 27 moving to bit 0. It clears the condition flag when that AND is zero and leaves the flag unchanged otherwise.
- R9: Bit 8 rotates the bus right by one place, with bit 0 moving to bit 27.
- R10: Bit 9 sets the condition flag and outranks a clear from R8. Without bit 9 or bit 6, the flag holds its value.
- R11: Bit 11 copies the bus into the output register, which always drives dataOut. Bit 12 asserts wrEn in that same cycle only, with the data address equal to the bus and dataOut equal to the output register's value at the start of the cycle.
- R12: When several sources target the bus, the order of precedence is: indirect load, immediate load, register read, XOR, AND-rotate, rotate-right.
- R13: Every destination in a word samples the bus as it stood at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instAddr | output | 7 | Address of the word being executed |
| instWord | input | 28 | Control word fetched at instAddr |
| dataIn | input | 28 | Data memory read value for the current data address |
| dataOut | output | 28 | Output register contents |
| dataAddr | output | 28 | Data memory address |
| wrEn | output | 1 | Write strobe: store dataOut at dataAddr at the next edge |

## Verification
The assertions assume that both memories answer in the same cycle: instWord must match instAddr, and dataIn must match dataAddr, before the clock edge. They also assume that reset is held through at least one edge at start-up. The bench drives instWord and dataIn itself, sets them well before each edge, and keeps them steady until the edge has passed. It reads the bus without clocking, by applying an all-zero word, which sends the bus to dataAddr.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int CTRL_W = 14;
  localparam int RSEL_W = 2;

  // Bit positions inside the control field; successor and alternate fields follow above.
  localparam int B_IMM  = 0;
  localparam int B_RSEL = 1;
  localparam int B_RRD  = 3;
  localparam int B_RWR  = 4;
  localparam int B_LDL  = 5;
  localparam int B_AND  = 6;
  localparam int B_XOR  = 7;
  localparam int B_ROR  = 8;
  localparam int B_SETC = 9;
  localparam int B_BR   = 10;
  localparam int B_OUT  = 11;
  localparam int B_WR   = 12;
  localparam int B_IND  = 13;

  typedef struct packed {
    logic              ldInd;
    logic              memWr;
    logic              outLd;
    logic              branch;
    logic              setC;
    logic              rotR;
    logic              xorL;
    logic              andRl;
    logic              ldL;
    logic              regWr;
    logic              regRd;
    logic [RSEL_W-1:0] regSel;
    logic              ldImm;
  } strobe_t;
endpackage

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int IA_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instWord,
  input  logic              condFlag,
  output strobe_t           strobes,
  output logic [IA_W-1:0]   succAddr,
  output logic [IA_W-1:0]   instAddr
);
  localparam int SUCC_LSB = CTRL_W;
  localparam int ALT_LSB  = CTRL_W + IA_W;

  logic [IA_W-1:0] altAddr;
  logic [IA_W-1:0] nextAddr;

  assign succAddr = instWord[SUCC_LSB +: IA_W];
  assign altAddr  = instWord[ALT_LSB +: IA_W];

  always_comb begin
    strobes        = '0;
    strobes.ldImm  = instWord[B_IMM];
    strobes.regSel = instWord[B_RSEL +: RSEL_W];
    strobes.regRd  = instWord[B_RRD];
    strobes.regWr  = instWord[B_RWR];
    strobes.ldL    = instWord[B_LDL];
    strobes.andRl  = instWord[B_AND];
    strobes.xorL   = instWord[B_XOR];
    strobes.rotR   = instWord[B_ROR];
    strobes.setC   = instWord[B_SETC];
    strobes.branch = instWord[B_BR];
    strobes.outLd  = instWord[B_OUT];
    strobes.memWr  = instWord[B_WR];
    strobes.ldInd  = instWord[B_IND];
  end

  always_comb begin
    if (strobes.branch)
      nextAddr = condFlag ? succAddr : altAddr;
    else if (strobes.ldImm || strobes.ldInd)
      nextAddr = altAddr;
    else
      nextAddr = succAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) instAddr <= '0;
    else     instAddr <= nextAddr;
  end
endmodule

// File: rtl/ucode_dpath.sv
module ucode_dpath
  import ucode_pkg::*;
#(
  parameter int DATA_W  = 28,
  parameter int IA_W    = 7,
  parameter int NUM_GPR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [IA_W-1:0]   succAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] busQ,
  output logic              condFlag
);
  localparam int PAD_W = DATA_W - IA_W;

  logic [DATA_W-1:0] logicQ;
  logic [DATA_W-1:0] outQ;
  logic [DATA_W-1:0] gpr [NUM_GPR];
  logic [DATA_W-1:0] gprRd;
  logic [DATA_W-1:0] andVal;
  logic [DATA_W-1:0] busNext;

  assign gprRd  = gpr[strobes.regSel];
  assign andVal = busQ & logicQ;

  // Indirect access uses the bus; an immediate load alone uses the successor field.
  assign dataAddr = (strobes.ldImm && !strobes.ldInd) ? {{PAD_W{1'b0}}, succAddr} : busQ;
  assign dataOut  = outQ;

  always_comb begin
    if (strobes.ldInd || strobes.ldImm) busNext = dataIn;
    else if (strobes.regRd)             busNext = gprRd;
    else if (strobes.xorL)              busNext = busQ ^ logicQ;
    else if (strobes.andRl)             busNext = {andVal[DATA_W-2:0], andVal[DATA_W-1]};
    else if (strobes.rotR)              busNext = {busQ[0], busQ[DATA_W-1:1]};
    else                                busNext = busQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busQ     <= '0;
      logicQ   <= '0;
      outQ     <= '0;
      condFlag <= 1'b0;
    end else begin
      busQ <= busNext;
      if (strobes.ldL)  logicQ <= busQ;
      if (strobes.outLd) outQ  <= busQ;
      if (strobes.setC)
        condFlag <= 1'b1;
      else if (strobes.andRl && (andVal == '0))
        condFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)
        gpr[g] <= '0;
      else if (strobes.regWr && (strobes.regSel == RSEL_W'(g)))
        gpr[g] <= busQ;
    end
  end
endmodule

// File: rtl/ucode_core.sv
module ucode_core
  import ucode_pkg::*;
#(
  parameter int DATA_W  = 28,
  parameter int IA_W    = 7,
  parameter int NUM_GPR = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [IA_W-1:0]   instAddr,
  input  logic [DATA_W-1:0] instWord,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataAddr,
  output logic              wrEn
);
  strobe_t           strobes;
  logic [IA_W-1:0]   succAddr;
  logic [DATA_W-1:0] busQ;
  logic              condFlag;

  ucode_ctrl #(.DATA_W(DATA_W), .IA_W(IA_W)) ctrl_i (
    .clk(clk), .rst(rst), .instWord(instWord), .condFlag(condFlag),
    .strobes(strobes), .succAddr(succAddr), .instAddr(instAddr)
  );

  ucode_dpath #(.DATA_W(DATA_W), .IA_W(IA_W), .NUM_GPR(NUM_GPR)) dpath_i (
    .clk(clk), .rst(rst), .strobes(strobes), .succAddr(succAddr), .dataIn(dataIn),
    .dataAddr(dataAddr), .dataOut(dataOut), .busQ(busQ), .condFlag(condFlag)
  );

  assign wrEn = strobes.memWr;
endmodule

// File: rtl/ucode_core_chk.sv
module ucode_core_chk #(
  parameter int DATA_W = 28,
  parameter int IA_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [IA_W-1:0]   instAddr,
  input logic [DATA_W-1:0] instWord,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataAddr,
  input logic [DATA_W-1:0] dataOut,
  input logic              wrEn,
  input logic [DATA_W-1:0] busQ,
  input logic              condFlag
);
  localparam int SL = 14;
  localparam int AL = 14 + IA_W;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (instAddr == '0 && dataOut == '0 && busQ == '0 && !condFlag));

  // R2
  default_succ_chk: assert property (@(posedge clk) disable iff (rst)
    (!instWord[0] && !instWord[13] && !instWord[10])
      |=> instAddr == $past(instWord[SL +: IA_W]));

  // R3
  load_alt_chk: assert property (@(posedge clk) disable iff (rst)
    ((instWord[0] || instWord[13]) && !instWord[10])
      |=> instAddr == $past(instWord[AL +: IA_W]));

  // R4
  ind_addr_chk: assert property (@(posedge clk) disable iff (rst)
    instWord[13] |-> dataAddr == busQ);

  // R4
  ind_data_chk: assert property (@(posedge clk) disable iff (rst)
    instWord[13] |=> busQ == $past(dataIn));

  // R5
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (instWord[10] && condFlag) |=> instAddr == $past(instWord[SL +: IA_W]));

  // R5
  branch_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (instWord[10] && !condFlag) |=> instAddr == $past(instWord[AL +: IA_W]));

  // R10
  setc_chk: assert property (@(posedge clk) disable iff (rst)
    instWord[9] |=> condFlag);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!instWord[9] && !instWord[6]) |=> $stable(condFlag));

  // R11
  out_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (instWord[11] && !instWord[0]) |=> dataOut == $past(dataAddr));

  // R11
  write_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !instWord[0]) |-> dataAddr == busQ);
endmodule

bind ucode_core ucode_core_chk #(.DATA_W(DATA_W), .IA_W(IA_W)) chk_i (
  .clk(clk), .rst(rst), .instAddr(instAddr), .instWord(instWord), .dataIn(dataIn),
  .dataAddr(dataAddr), .dataOut(dataOut), .wrEn(wrEn), .busQ(busQ), .condFlag(condFlag)
);

// File: tb/ucode_core_tb_top.sv
module ucode_core_tb_top;
  localparam [13:0] M_IMM = 14'h0001, M_RRD = 14'h0008, M_RWR = 14'h0010,
                    M_LDL = 14'h0020, M_AND = 14'h0040, M_XOR = 14'h0080,
                    M_ROR = 14'h0100, M_SC  = 14'h0200, M_BR  = 14'h0400,
                    M_OUT = 14'h0800, M_WR  = 14'h1000, M_IND = 14'h2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  instAddr;
  logic [27:0] instWord = '0;
  logic [27:0] dataIn = '0;
  logic [27:0] dataOut, dataAddr;
  logic        wrEn;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ucode_core dut_i (
    .clk(clk), .rst(rst), .instAddr(instAddr), .instWord(instWord),
    .dataIn(dataIn), .dataOut(dataOut), .dataAddr(dataAddr), .wrEn(wrEn)
  );

  function automatic [27:0] mk(input [6:0] p, input [6:0] n, input [13:0] c);
    return {p, n, c};
  endfunction
  function automatic [13:0] rsel(input int r);
    return 14'(r << 1);
  endfunction
  function automatic [27:0] rotl(input [27:0] v);
    return {v[26:0], v[27]};
  endfunction
  function automatic [27:0] rotr(input [27:0] v);
    return {v[0], v[27:1]};
  endfunction

  task automatic chk(input string req, input [27:0] act, input [27:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply a word, clock once, then park on an all-zero word.
  task automatic run(input [27:0] w, input [27:0] din);
    instWord = w; dataIn = din;
    @(posedge clk); #1;
    instWord = '0;
  endtask

  // An all-zero word routes the bus to dataAddr without clocking.
  task automatic peek(output [27:0] v);
    instWord = '0; #0.5;
    v = dataAddr;
  endtask

  task automatic ldi(input [27:0] v);
    run(mk(7'd0, 7'd0, M_IMM), v);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 28'd0, 28'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [27:0] v;
    logic [27:0] gv [4];
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    peek(v);
    chk("R1 bus", v, 28'd0);
    chk("R1 instAddr", 28'(instAddr), 28'd0);
    chk("R1 dataOut", dataOut, 28'd0);
    chk("R1 wrEn", 28'(wrEn), 28'd0);
    for (int g = 0; g < 4; g++) begin
      run(mk(7'd0, 7'd0, M_RRD | rsel(g)), 28'd0);
      peek(v); chk("R1 gpr", v, 28'd0);
    end
    run(mk(7'd0, 7'd0, M_XOR), 28'd0);
    peek(v); chk("R1 logic reg", v, 28'd0);
    run(mk(7'h11, 7'h22, M_BR), 28'd0);
    chk("R1 flag clear", 28'(instAddr), 28'h11);

    // R2 default successor sweep
    for (int n = 0; n < 128; n++) begin
      run(mk(~7'(n), 7'(n), 14'd0), 28'd0);
      chk("R2 succ", 28'(instAddr), 28'(n));
    end

    // R3 immediate load
    for (int i = 0; i < 8; i++) begin
      logic [27:0] val;
      val = 28'(28'h1234567 * (i + 1) + i);
      instWord = mk(7'(i + 10), 7'(i * 3 + 1), M_IMM); dataIn = val; #1;
      chk("R3 addr", dataAddr, 28'(i * 3 + 1));
      run(instWord, val);
      chk("R3 next", 28'(instAddr), 28'(i + 10));
      peek(v); chk("R3 bus", v, val);
    end

    // R4 indirect load
    ldi(28'h00000a5);
    instWord = mk(7'h33, 7'h44, M_IND); dataIn = 28'h7654321; #1;
    chk("R4 addr", dataAddr, 28'h00000a5);
    run(instWord, dataIn);
    chk("R4 next", 28'(instAddr), 28'h33);
    peek(v); chk("R4 bus", v, 28'h7654321);
    // R4 outranks immediate
    ldi(28'h0000042);
    instWord = mk(7'h05, 7'h06, M_IND | M_IMM); dataIn = 28'h0abcdef; #1;
    chk("R4 over R3 addr", dataAddr, 28'h0000042);
    run(instWord, dataIn);

    // R6 general registers
    for (int g = 0; g < 4; g++) begin
      gv[g] = 28'(28'h0f0f0f1 << g) ^ 28'(g * 7);
      ldi(gv[g]);
      run(mk(7'd0, 7'd0, M_RWR | rsel(g)), 28'd0);
    end
    for (int g = 3; g >= 0; g--) begin
      run(mk(7'd0, 7'd0, M_RRD | rsel(g)), 28'd0);
      peek(v); chk("R6 readback", v, gv[g]);
    end

    // R7 R8 R9 operand sweep
    for (int i = 0; i < 6; i++) begin
      logic [27:0] a, b;
      a = 28'(32'h9e3779b * (i + 1));
      b = 28'(32'h5bd1e99 * (i + 3)) | 28'(i == 5 ? 28'h8000000 : 0);
      ldi(a); run(mk(7'd0, 7'd0, M_LDL), 28'd0);
      ldi(b); run(mk(7'd0, 7'd0, M_XOR), 28'd0);
      peek(v); chk("R7 xor", v, a ^ b);
      ldi(b); run(mk(7'd0, 7'd0, M_AND), 28'd0);
      peek(v); chk("R8 androt", v, rotl(a & b));
      ldi(b); run(mk(7'd0, 7'd0, M_ROR), 28'd0);
      peek(v); chk("R9 rotr", v, rotr(b));
    end

    // R8 R10 condition flag
    run(mk(7'd0, 7'd0, M_SC), 28'd0);
    run(mk(7'h11, 7'h22, M_BR), 28'd0);
    chk("R10 setc then branch", 28'(instAddr), 28'h22);
    ldi(28'h00000f0); run(mk(7'd0, 7'd0, M_LDL), 28'd0);
    ldi(28'h0000f00); run(mk(7'd0, 7'd0, M_AND), 28'd0);
    run(mk(7'h11, 7'h22, M_BR), 28'd0);
    chk("R8 zero clears C", 28'(instAddr), 28'h11);
    ldi(28'h0000f00); run(mk(7'd0, 7'd0, M_AND | M_SC), 28'd0);
    run(mk(7'h11, 7'h22, M_BR), 28'd0);
    chk("R10 setc beats clear", 28'(instAddr), 28'h22);
    ldi(28'h0000ff0); run(mk(7'd0, 7'd0, M_AND), 28'd0);
    run(mk(7'h11, 7'h22, M_BR), 28'd0);
    chk("R8 nonzero keeps C", 28'(instAddr), 28'h22);
    run(mk(7'd0, 7'd0, M_XOR | M_ROR | M_LDL), 28'd0);
    run(mk(7'h13, 7'h24, M_BR | M_IMM), 28'd5);
    chk("R5 branch beats load", 28'(instAddr), 28'h24);

    // R11 output register and write strobe
    ldi(28'h1357bdf); run(mk(7'd0, 7'd0, M_OUT), 28'd0);
    chk("R11 dataOut", dataOut, 28'h1357bdf);
    ldi(28'h0000077);
    instWord = mk(7'd0, 7'd0, M_WR | M_OUT); #1;
    chk("R11 wrEn", 28'(wrEn), 28'd1);
    chk("R11 write addr", dataAddr, 28'h0000077);
    chk("R11 write data", dataOut, 28'h1357bdf);
    run(instWord, 28'd0);
    chk("R11 strobe drops", 28'(wrEn), 28'd0);
    chk("R11 out updated", dataOut, 28'h0000077);

    // R12 bus source precedence
    run(mk(7'd0, 7'd0, M_IMM | M_RRD | M_XOR), 28'h0dddddd);
    peek(v); chk("R12 load first", v, 28'h0dddddd);
    run(mk(7'd0, 7'd0, M_RRD | rsel(2) | M_XOR | M_AND), 28'd0);
    peek(v); chk("R12 reg over alu", v, gv[2]);
    ldi(28'h00000f0); run(mk(7'd0, 7'd0, M_LDL), 28'd0);
    ldi(28'h0000ff0); run(mk(7'd0, 7'd0, M_XOR | M_AND | M_ROR), 28'd0);
    peek(v); chk("R12 xor over and", v, 28'h0000f00);
    run(mk(7'd0, 7'd0, M_AND | M_ROR), 28'd0);
    peek(v); chk("R12 and over ror", v, rotl(28'h0000f00 & 28'h00000f0));

    // R13 concurrent sampling
    ldi(28'h0aaaaaa);
    run(mk(7'd0, 7'd0, M_LDL | M_RRD | rsel(1)), 28'd0);
    peek(v); chk("R13 bus gets reg", v, gv[1]);
    run(mk(7'd0, 7'd0, M_XOR | M_OUT | M_RWR | rsel(3)), 28'd0);
    chk("R13 out old bus", dataOut, gv[1]);
    peek(v); chk("R13 L old bus", v, gv[1] ^ 28'h0aaaaaa);
    run(mk(7'd0, 7'd0, M_RRD | rsel(3)), 28'd0);
    peek(v); chk("R13 reg old bus", v, gv[1]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule